// File: doc/BRIEF.md
# Phase-Delay Chroma Generator

This block produces the digital colour and brightness outputs that feed a composite video encoder. The colour output is a square-wave subcarrier with a 14-step period, half high and half low. A 4-bit hue selects how far that wave is shifted behind a reference phase. Hue 0 carries no colour. Hue 1 sits exactly on the reference phase. Each further hue adds one step of delay, so hue 15 wraps back onto the reference.

During horizontal blanking the reference burst is sent on the same output. Alongside the colour output, three luminance bits are taken from the low nibble of the colour code. A free-running phase counter moves one step on each cycle where the subcarrier-step enable is high. A fixed delay of one such step per hue replaces an analog delay trim.

Both outputs are registered. Each output value is computed from the phase count and the inputs sampled at the same rising clock edge.

Top module: `chroma_phase_gen`

## Requirements
- R1: While `rst_n` is low, `chroma_out` and `luma_out` are 0, and the phase count is 0. The first rising edge after release computes the outputs from phase 0.
- R2: The phase count advances by one, modulo 14, only on rising edges where `step_en` is 1. When `step_en` is 0 the count holds.
- R3: With hue 1 (`color_code[7:4]` = 1), no blank and no burst, `chroma_out` is 1 when the phase count is 0 to 6 and 0 when it is 7 to 13.
- R4: For hue n from 2 to 14, `chroma_out` is 1 exactly when ((count − (n−1)) mod 14) < 7.
- R5: Hue 15 has a delay of 14 steps and gives the same waveform as hue 1.
- R6: Hue 0 gives `chroma_out` = 0 outside the burst window.
- R7: While `burst_win` is 1, `chroma_out` follows the hue-1 waveform, whatever the values of `color_code` and `blank`.
- R8: While `blank` is 1 and `burst_win` is 0, `chroma_out` is 0.
- R9: With `blank` = 0, `luma_out` equals `color_code[3:1]`, and `color_code[0]` has no effect on either output.
- R10: While `blank` is 1, `luma_out` is 0.
- R11: Both outputs change one clock after the inputs and the phase count that produce them are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Subcarrier-step tick; advances the phase count |
| color_code | input | 8 | Hue in bits 7:4, luminance in bits 3:1, bit 0 unused |
| blank | input | 1 | Blanking flag |
| burst_win | input | 1 | Reference-burst window flag |
| chroma_out | output | 1 | Colour subcarrier output |
| luma_out | output | 3 | Luminance output |

## Verification
A wrong phase count cannot be seen while the output is dark. It shows up on `chroma_out` within one clock of a lit hue or a burst window. The bench therefore keeps a hue or the burst visible across every phase-count value, and also across runs where `step_en` is held low. A delay that is off by one step for a single hue shows only at the two edges of that hue's waveform. For that reason every hue is swept over a full 14-step period. Luminance and blanking errors show on `luma_out` on the very next clock.

// File: rtl/chroma_pkg.sv
package chroma_pkg;
    localparam int CHR_STEPS  = 14;
    localparam int CHR_HUE_W  = 4;
    localparam int CHR_LUMA_W = 3;
    localparam int CHR_CODE_W = 8;

    typedef enum logic [1:0] {
        CHR_OFF   = 2'd0,
        CHR_BURST = 2'd1,
        CHR_HUE   = 2'd2
    } chr_mode_e;
endpackage

// File: rtl/chroma_phase_ctr.sv
module chroma_phase_ctr #(
    parameter int STEPS = chroma_pkg::CHR_STEPS,
    localparam int CW   = $clog2(STEPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_en,
    output logic [CW-1:0] phase_o
);
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (step_en) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign phase_o = cnt_q;
endmodule

// File: rtl/chroma_hue_phase.sv
module chroma_hue_phase #(
    parameter int STEPS = chroma_pkg::CHR_STEPS,
    parameter int HUE_W = chroma_pkg::CHR_HUE_W,
    localparam int CW   = $clog2(STEPS),
    localparam int HUES = 2 ** HUE_W
) (
    input  logic [CW-1:0]   phase_i,
    output logic [HUES-1:0] wave_o
);
    localparam logic [CW:0] STEPS_W = (CW+1)'(STEPS);
    localparam logic [CW:0] HALF_W  = (CW+1)'(STEPS / 2);

    for (genvar h = 0; h < HUES; h++) begin : g_hue
        if (h == 0) begin : g_dark
            assign wave_o[h] = 1'b0;
        end else begin : g_lit
            localparam int          DLY = (h - 1) % STEPS;
            localparam logic [CW:0] OFS = (CW+1)'(STEPS - DLY);
            logic [CW:0] shifted;
            always_comb begin
                shifted = {1'b0, phase_i} + OFS;
                if (shifted >= STEPS_W) shifted = shifted - STEPS_W;
            end
            assign wave_o[h] = (shifted < HALF_W);
        end
    end
endmodule

// File: rtl/chroma_luma_map.sv
module chroma_luma_map #(
    parameter int LUMA_W = chroma_pkg::CHR_LUMA_W
) (
    input  logic [LUMA_W-1:0] level_i,
    input  logic              blank_i,
    output logic [LUMA_W-1:0] luma_o
);
    always_comb begin
        luma_o = blank_i ? '0 : level_i;
    end
endmodule

// File: rtl/chroma_phase_gen.sv
module chroma_phase_gen #(
    parameter int STEPS  = chroma_pkg::CHR_STEPS,
    parameter int HUE_W  = chroma_pkg::CHR_HUE_W,
    parameter int LUMA_W = chroma_pkg::CHR_LUMA_W,
    parameter int CODE_W = chroma_pkg::CHR_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic [CODE_W-1:0] color_code,
    input  logic              blank,
    input  logic              burst_win,
    output logic              chroma_out,
    output logic [LUMA_W-1:0] luma_out
);
    import chroma_pkg::*;

    localparam int CW   = $clog2(STEPS);
    localparam int HUES = 2 ** HUE_W;

    typedef struct packed {
        logic              chroma;
        logic [LUMA_W-1:0] luma;
    } out_t;

    out_t            out_d, out_q;
    logic [CW-1:0]   phase;
    logic [HUES-1:0] wave;
    logic [LUMA_W-1:0] luma_nx;
    logic [HUE_W-1:0]  hue;
    chr_mode_e         mode;
    logic              unused_code_lsb;

    assign hue             = color_code[CODE_W-1 -: HUE_W];
    assign unused_code_lsb = color_code[0];

    chroma_phase_ctr #(.STEPS(STEPS)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (step_en),
        .phase_o (phase)
    );

    chroma_hue_phase #(.STEPS(STEPS), .HUE_W(HUE_W)) u_hue (
        .phase_i (phase),
        .wave_o  (wave)
    );

    chroma_luma_map #(.LUMA_W(LUMA_W)) u_luma (
        .level_i (color_code[LUMA_W:1]),
        .blank_i (blank),
        .luma_o  (luma_nx)
    );

    always_comb begin
        if (burst_win)                 mode = CHR_BURST;
        else if (blank || hue == '0)   mode = CHR_OFF;
        else                           mode = CHR_HUE;

        out_d.luma = luma_nx;
        unique case (mode)
            CHR_BURST: out_d.chroma = wave[1];
            CHR_HUE:   out_d.chroma = wave[hue];
            default:   out_d.chroma = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign chroma_out = out_q.chroma;
    assign luma_out   = out_q.luma;
endmodule

// File: rtl/chroma_phase_chk.sv
module chroma_phase_chk #(
    parameter int HUE_W  = 4,
    parameter int LUMA_W = 3,
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] color_code,
    input logic              blank,
    input logic              burst_win,
    input logic              chroma_out,
    input logic [LUMA_W-1:0] luma_out
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!chroma_out && luma_out == '0)); // R1

    AST_HUE0_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_win && color_code[CODE_W-1 -: HUE_W] == '0) |=> !chroma_out); // R6

    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (blank && !burst_win) |=> !chroma_out); // R8

    AST_LUMA_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !blank |=> (luma_out == $past(color_code[LUMA_W:1]))); // R9

    AST_BLANK_LUMA: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> (luma_out == '0)); // R10
endmodule

bind chroma_phase_gen chroma_phase_chk #(
    .HUE_W(HUE_W), .LUMA_W(LUMA_W), .CODE_W(CODE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .color_code (color_code),
    .blank      (blank),
    .burst_win  (burst_win),
    .chroma_out (chroma_out),
    .luma_out   (luma_out)
);

// File: tb/chroma_phase_gen_tb_top.sv
`timescale 1ns/1ps
module chroma_phase_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_en = 1'b0;
    logic [7:0] color_code = 8'h00;
    logic       blank = 1'b0;
    logic       burst_win = 1'b0;
    logic       chroma_out;
    logic [2:0] luma_out;

    int checks = 0;
    int errors = 0;
    int ref_cnt = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    chroma_phase_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (step_en),
        .color_code (color_code),
        .blank      (blank),
        .burst_win  (burst_win),
        .chroma_out (chroma_out),
        .luma_out   (luma_out)
    );

    function automatic logic exp_chroma(int c, logic [7:0] code, logic bl, logic bw);
        int h;
        h = bw ? 1 : int'(code[7:4]);
        if (!bw && (bl || h == 0)) return 1'b0;
        return (((c - (h - 1) + 28) % 14) < 7);
    endfunction

    function automatic logic [2:0] exp_luma(logic [7:0] code, logic bl);
        return bl ? 3'd0 : code[3:1];
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Inputs are set at a negedge; one clock later both outputs are compared.
    task automatic tick(string req);
        logic       ec;
        logic [2:0] el;
        ec = exp_chroma(ref_cnt, color_code, blank, burst_win);
        el = exp_luma(color_code, blank);
        @(posedge clk);
        if (step_en) ref_cnt = (ref_cnt + 1) % 14;
        @(negedge clk);
        check({req, " chroma"}, int'(chroma_out), int'(ec));
        check({req, " luma"}, int'(luma_out), int'(el));
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step_en = 1'b1; color_code = 8'h1E; blank = 1'b0; burst_win = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 chroma in reset", int'(chroma_out), 0);
        check("R1 luma in reset", int'(luma_out), 0);
        rst_n = 1'b1;
        ref_cnt = 0;
        tick("R1 first edge");
    endtask

    task automatic t_hue1();
        color_code = 8'h16; step_en = 1'b1;
        for (int i = 0; i < 28; i++) tick("R3 R11 hue1");
    endtask

    task automatic t_hues();
        step_en = 1'b1;
        for (int h = 2; h < 16; h++) begin
            color_code = {h[3:0], 4'h8};
            for (int i = 0; i < 14; i++) tick(h == 15 ? "R5 hue15" : "R4 hue delay");
        end
    endtask

    task automatic t_hold();
        color_code = 8'h14; step_en = 1'b1;
        while (ref_cnt != 5) tick("R2 align");
        step_en = 1'b0;
        for (int i = 0; i < 6; i++) tick("R2 hold");
        step_en = 1'b1;
        for (int i = 0; i < 4; i++) tick("R2 resume");
        color_code = 8'h74;
        step_en = 1'b0;
        for (int i = 0; i < 3; i++) tick("R2 hold hue7");
        step_en = 1'b1;
        for (int i = 0; i < 14; i++) tick("R2 wrap");
    endtask

    task automatic t_hue0();
        step_en = 1'b1; color_code = 8'h0E;
        for (int i = 0; i < 14; i++) tick("R6 hue0");
    endtask

    task automatic t_burst();
        step_en = 1'b1; blank = 1'b1; burst_win = 1'b1;
        for (int i = 0; i < 14; i++) begin
            color_code = (i % 2 == 0) ? 8'h00 : 8'h9B;
            tick("R7 burst");
        end
        blank = 1'b0; color_code = 8'h5A;
        for (int i = 0; i < 7; i++) tick("R7 burst unblanked");
        burst_win = 1'b0;
    endtask

    task automatic t_blank();
        step_en = 1'b1; blank = 1'b1; color_code = 8'h3F;
        for (int i = 0; i < 14; i++) tick("R8 R10 blank");
        blank = 1'b0;
        tick("R10 blank release");
    endtask

    task automatic t_luma();
        step_en = 1'b1; blank = 1'b0;
        for (int v = 0; v < 16; v++) begin
            color_code = {4'h0, v[3:0]};
            tick("R9 luma");
        end
        color_code = 8'h26;
        tick("R9 lsb0");
        color_code = 8'h27;
        tick("R9 lsb1");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_hue1();
        t_hues();
        t_hold();
        t_hue0();
        t_burst();
        t_blank();
        t_luma();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule